// File: doc/BRIEF.md
# Bank Window Unit

This block sits beside a Z80-style processor on a shared backplane and widens the reach of the two upper 16 KiB regions of its 64 KiB address space. It holds one 8-bit page register per upper region. Software loads a page register by writing a byte to one of two fixed I/O ports. While a memory cycle addresses one of the upper regions, the matching page register drives the backplane bank address lines. Memory cards combine those lines with the low address bits to pick a page.

The lower two regions (boot ROM and main RAM) carry no page number. The bank lines rest at zero for those regions and between memory cycles. Software can read either page register back through an I/O read of the same port. The read-back byte comes with an enable flag for the data bus driver. An I/O read never changes a register. A long I/O write loads its register only once.

Top module: `bank_window_unit`

## Requirements
- R1: An I/O write (iorq_n and wr_n low) to port 0x00 stores din into the lower window register at the first rising clock edge of that I/O cycle.
- R2: An I/O write to port 0x01 stores din into the upper window register at the first rising clock edge of that I/O cycle.
- R3: While mreq_n is low and addr lies in 0x8000–0xBFFF inclusive, ba equals the lower window register.
- R4: While mreq_n is low and addr lies in 0xC000–0xFFFF inclusive, ba equals the upper window register.
- R5: ba is 0x00 whenever mreq_n is high or addr lies in 0x0000–0x7FFF.
- R6: Port matching looks only at addr[7:0]; any value of addr[15:8] selects the same port for both writes and reads.
- R7: An I/O read (rd_n low, wr_n high) of port 0x00 or 0x01 leaves both registers unchanged.
- R8: During an I/O read of port 0x00 or 0x01, dout carries the matching register and dout_oe is 1; at all other times dout_oe is 0 and dout is 0x00.
- R9: Reset (rst_n low) clears both registers to 0x00.
- R10: A register loads at most once per I/O cycle. Data that changes while iorq_n stays low after the load is ignored until iorq_n has been high at a rising edge.
- R11: I/O writes to ports 0x02–0xFF and memory writes to any address leave both registers unchanged.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Bus clock; registers load on the rising edge |
| rst_n | input | 1 | Active-low asynchronous reset |
| addr | input | 16 | Processor address bus |
| din | input | 8 | Processor data bus, source of register loads |
| iorq_n | input | 1 | Active-low I/O request |
| mreq_n | input | 1 | Active-low memory request |
| wr_n | input | 1 | Active-low write strobe |
| rd_n | input | 1 | Active-low read strobe |
| ba | output | 8 | Bank address bus toward the memory cards |
| dout | output | 8 | Read-back byte for I/O reads of the page ports |
| dout_oe | output | 1 | High while dout should drive the data bus |

## Verification
The bench builds the unit with its default parameters: a 16-bit address, 8-bit pages, two windows and a port base of 0x00. With these values the exact region edges 0x7FFF, 0x8000, 0xBFFF, 0xC000 and 0xFFFF can be probed directly. The full upper address byte is also free for port-alias tests, so walking port numbers, region boundaries and aliased ports in a short table reaches every decode path. Directed cases cover a write held over several clocks with changing data, memory writes that look like port writes, and a reset pulse in mid-run.

// File: rtl/bank_pkg.sv
package bank_pkg;

    localparam int BK_ADDR_W    = 16;
    localparam int BK_DATA_W    = 8;
    localparam int BK_IO_W      = 8;
    localparam int BK_WINDOWS   = 2;
    localparam int BK_PORT_BASE = 0;

    // Address space splits into 2*nwin equal regions; the upper nwin are windows.
    function automatic int rgn_bits(input int nwin);
        return $clog2(2 * nwin);
    endfunction

endpackage

// File: rtl/bank_port_decode.sv
module bank_port_decode #(
    parameter int                IO_W      = bank_pkg::BK_IO_W,
    parameter int                NUM_WIN   = bank_pkg::BK_WINDOWS,
    parameter logic [IO_W-1:0]   PORT_BASE = '0
) (
    input  logic [IO_W-1:0]    port,
    input  logic               iorq_n,
    input  logic               wr_n,
    input  logic               rd_n,
    output logic [NUM_WIN-1:0] wr_hit,
    output logic [NUM_WIN-1:0] rd_hit
);

    logic io_wr;
    logic io_rd;

    assign io_wr = !iorq_n && !wr_n;
    assign io_rd = !iorq_n && !rd_n && wr_n;

    generate
        for (genvar g = 0; g < NUM_WIN; g++) begin : g_port
            localparam logic [IO_W-1:0] PNUM = PORT_BASE + IO_W'(g);
            logic match;
            assign match     = (port == PNUM);
            assign wr_hit[g] = io_wr && match;
            assign rd_hit[g] = io_rd && match;
        end
    endgenerate

endmodule

// File: rtl/bank_regfile.sv
module bank_regfile #(
    parameter int DATA_W  = bank_pkg::BK_DATA_W,
    parameter int NUM_WIN = bank_pkg::BK_WINDOWS
) (
    input  logic                             clk,
    input  logic                             rst_n,
    input  logic                             iorq_n,
    input  logic [NUM_WIN-1:0]               wr_hit,
    input  logic [DATA_W-1:0]                din,
    output logic [NUM_WIN-1:0][DATA_W-1:0]   win_q
);

    typedef struct packed {
        logic [NUM_WIN-1:0][DATA_W-1:0] win;
        logic                           taken;
    } rf_state_t;

    rf_state_t st_d;
    rf_state_t st_q;

    always_comb begin
        st_d = st_q;
        if (iorq_n) begin
            st_d.taken = 1'b0;
        end else if ((|wr_hit) && !st_q.taken) begin
            st_d.taken = 1'b1;
            for (int i = 0; i < NUM_WIN; i++) begin
                if (wr_hit[i]) begin
                    st_d.win[i] = din;
                end
            end
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            st_q <= '0;
        end else begin
            st_q <= st_d;
        end
    end

    assign win_q = st_q.win;

endmodule

// File: rtl/bank_steer.sv
module bank_steer #(
    parameter int ADDR_W  = bank_pkg::BK_ADDR_W,
    parameter int DATA_W  = bank_pkg::BK_DATA_W,
    parameter int NUM_WIN = bank_pkg::BK_WINDOWS
) (
    input  logic [ADDR_W-1:0]               addr,
    input  logic                            mreq_n,
    input  logic [NUM_WIN-1:0][DATA_W-1:0]  win,
    output logic [DATA_W-1:0]               ba
);

    localparam int RGN_W    = bank_pkg::rgn_bits(NUM_WIN);
    localparam int SPAN_LOG = ADDR_W - RGN_W;

    typedef logic [ADDR_W:0] wide_t;

    wide_t              addr_w;
    logic [NUM_WIN-1:0] sel;

    assign addr_w = {1'b0, addr};

    generate
        for (genvar g = 0; g < NUM_WIN; g++) begin : g_win
            localparam wide_t LO = wide_t'(NUM_WIN + g) << SPAN_LOG;
            localparam wide_t HI = LO + (wide_t'(1) << SPAN_LOG);
            assign sel[g] = !mreq_n && (addr_w >= LO) && (addr_w < HI);
        end
    endgenerate

    always_comb begin
        ba = '0;
        for (int i = 0; i < NUM_WIN; i++) begin
            if (sel[i]) begin
                ba = win[i];
            end
        end
    end

endmodule

// File: rtl/bank_window_unit.sv
module bank_window_unit #(
    parameter int ADDR_W    = bank_pkg::BK_ADDR_W,
    parameter int DATA_W    = bank_pkg::BK_DATA_W,
    parameter int IO_W      = bank_pkg::BK_IO_W,
    parameter int NUM_WIN   = bank_pkg::BK_WINDOWS,
    parameter int PORT_BASE = bank_pkg::BK_PORT_BASE
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [ADDR_W-1:0] addr,
    input  logic [DATA_W-1:0] din,
    input  logic              iorq_n,
    input  logic              mreq_n,
    input  logic              wr_n,
    input  logic              rd_n,
    output logic [DATA_W-1:0] ba,
    output logic [DATA_W-1:0] dout,
    output logic              dout_oe
);

    logic [NUM_WIN-1:0]              wr_hit;
    logic [NUM_WIN-1:0]              rd_hit;
    logic [NUM_WIN-1:0][DATA_W-1:0]  win_q;

    bank_port_decode #(
        .IO_W      (IO_W),
        .NUM_WIN   (NUM_WIN),
        .PORT_BASE (IO_W'(PORT_BASE))
    ) u_dec (
        .port   (addr[IO_W-1:0]),
        .iorq_n (iorq_n),
        .wr_n   (wr_n),
        .rd_n   (rd_n),
        .wr_hit (wr_hit),
        .rd_hit (rd_hit)
    );

    bank_regfile #(
        .DATA_W  (DATA_W),
        .NUM_WIN (NUM_WIN)
    ) u_rf (
        .clk    (clk),
        .rst_n  (rst_n),
        .iorq_n (iorq_n),
        .wr_hit (wr_hit),
        .din    (din),
        .win_q  (win_q)
    );

    bank_steer #(
        .ADDR_W  (ADDR_W),
        .DATA_W  (DATA_W),
        .NUM_WIN (NUM_WIN)
    ) u_steer (
        .addr   (addr),
        .mreq_n (mreq_n),
        .win    (win_q),
        .ba     (ba)
    );

    always_comb begin
        dout    = '0;
        dout_oe = 1'b0;
        for (int i = 0; i < NUM_WIN; i++) begin
            if (rd_hit[i]) begin
                dout    = win_q[i];
                dout_oe = 1'b1;
            end
        end
    end

endmodule

// File: rtl/bank_window_chk.sv
module bank_window_chk #(
    parameter int DATA_W    = 8,
    parameter int NUM_WIN   = 2,
    parameter int IO_W      = 8,
    parameter int PORT_BASE = 0
) (
    input logic                        clk,
    input logic                        rst_n,
    input logic [IO_W-1:0]             io_port,
    input logic [1:0]                  rgn,
    input logic [DATA_W-1:0]           din,
    input logic                        iorq_n,
    input logic                        mreq_n,
    input logic                        wr_n,
    input logic                        rd_n,
    input logic [DATA_W-1:0]           ba,
    input logic [DATA_W-1:0]           dout,
    input logic                        dout_oe,
    input logic [NUM_WIN*DATA_W-1:0]   win_flat
);

    logic              port_lo;
    logic              port_hi;
    logic              armed_q;
    logic [DATA_W-1:0] lo_w;
    logic [DATA_W-1:0] hi_w;

    assign port_lo = (io_port == IO_W'(PORT_BASE));
    assign port_hi = (io_port == IO_W'(PORT_BASE + 1));
    assign lo_w    = win_flat[DATA_W-1:0];
    assign hi_w    = win_flat[2*DATA_W-1:DATA_W];

    // Independent tracker of whether the current I/O cycle may still load.
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            armed_q <= 1'b1;
        end else if (iorq_n) begin
            armed_q <= 1'b1;
        end else if (!wr_n && (port_lo || port_hi)) begin
            armed_q <= 1'b0;
        end
    end

    assert_load_lo_R1: assert property (@(posedge clk) disable iff (!rst_n)
        (!iorq_n && !wr_n && port_lo && armed_q) |=> (lo_w == $past(din)));

    assert_load_hi_R2: assert property (@(posedge clk) disable iff (!rst_n)
        (!iorq_n && !wr_n && port_hi && armed_q) |=> (hi_w == $past(din)));

    assert_ba_lo_R3: assert property (@(posedge clk) disable iff (!rst_n)
        (!mreq_n && rgn == 2'b10) |-> (ba == lo_w));

    assert_ba_hi_R4: assert property (@(posedge clk) disable iff (!rst_n)
        (!mreq_n && rgn == 2'b11) |-> (ba == hi_w));

    assert_ba_idle_R5: assert property (@(posedge clk) disable iff (!rst_n)
        (mreq_n || !rgn[1]) |-> (ba == '0));

    assert_no_write_R7: assert property (@(posedge clk) disable iff (!rst_n)
        (iorq_n || wr_n) |=> $stable(win_flat));

    assert_oe_R8: assert property (@(posedge clk) disable iff (!rst_n)
        dout_oe |-> (!iorq_n && !rd_n && (port_lo || port_hi)));

    assert_dout_quiet_R8: assert property (@(posedge clk) disable iff (!rst_n)
        !dout_oe |-> (dout == '0));

    assert_reset_R9: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(rst_n) |-> (win_flat == '0));

    assert_once_R10: assert property (@(posedge clk) disable iff (!rst_n)
        (!iorq_n && !armed_q) |=> $stable(win_flat));

endmodule

bind bank_window_unit bank_window_chk #(
    .DATA_W    (DATA_W),
    .NUM_WIN   (NUM_WIN),
    .IO_W      (IO_W),
    .PORT_BASE (PORT_BASE)
) u_chk (
    .clk      (clk),
    .rst_n    (rst_n),
    .io_port  (addr[IO_W-1:0]),
    .rgn      (addr[ADDR_W-1 -: 2]),
    .din      (din),
    .iorq_n   (iorq_n),
    .mreq_n   (mreq_n),
    .wr_n     (wr_n),
    .rd_n     (rd_n),
    .ba       (ba),
    .dout     (dout),
    .dout_oe  (dout_oe),
    .win_flat (win_q)
);

// File: tb/sim_bank_window_unit.sv
module sim_bank_window_unit;

    logic        clk;
    logic        rst_n;
    logic [15:0] addr;
    logic [7:0]  din;
    logic        iorq_n;
    logic        mreq_n;
    logic        wr_n;
    logic        rd_n;
    logic [7:0]  ba;
    logic [7:0]  dout;
    logic        dout_oe;

    int checks = 0;
    int errors = 0;
    bit done   = 0;

    bank_window_unit u0 (
        .clk     (clk),
        .rst_n   (rst_n),
        .addr    (addr),
        .din     (din),
        .iorq_n  (iorq_n),
        .mreq_n  (mreq_n),
        .wr_n    (wr_n),
        .rd_n    (rd_n),
        .ba      (ba),
        .dout    (dout),
        .dout_oe (dout_oe)
    );

    initial clk = 1'b0;
    always #5 clk = ~clk;

    // op: 0 = I/O write, 1 = I/O read (expect dout, oe=1), 2 = memory probe (expect ba)
    typedef struct packed {
        logic [1:0]  op;
        logic [15:0] a;
        logic [7:0]  d;
        logic [7:0]  exp;
        logic [3:0]  req;
    } vec_t;

    localparam int NV = 19;
    localparam vec_t VECS [NV] = '{
        '{2'd0, 16'h0000, 8'hA5, 8'h00, 4'd1},   // R1 load lower window
        '{2'd2, 16'h8000, 8'h00, 8'hA5, 4'd3},   // R3 low edge
        '{2'd2, 16'hBFFF, 8'h00, 8'hA5, 4'd3},   // R3 high edge
        '{2'd0, 16'h0001, 8'h3C, 8'h00, 4'd2},   // R2 load upper window
        '{2'd2, 16'hC000, 8'h00, 8'h3C, 4'd4},   // R4 low edge
        '{2'd2, 16'hFFFF, 8'h00, 8'h3C, 4'd4},   // R4 high edge
        '{2'd2, 16'h7FFF, 8'h00, 8'h00, 4'd5},   // R5 top of RAM region
        '{2'd2, 16'h0000, 8'h00, 8'h00, 4'd5},   // R5 ROM region
        '{2'd1, 16'h0000, 8'h00, 8'hA5, 4'd8},   // R8 read lower
        '{2'd1, 16'h0001, 8'h00, 8'h3C, 4'd8},   // R8 read upper
        '{2'd2, 16'h8123, 8'h00, 8'hA5, 4'd7},   // R7 lower kept after read
        '{2'd2, 16'hC001, 8'h00, 8'h3C, 4'd7},   // R7 upper kept after read
        '{2'd0, 16'h7F01, 8'hC3, 8'h00, 4'd6},   // R6 aliased port 1
        '{2'd2, 16'hD000, 8'h00, 8'hC3, 4'd6},   // R6 alias reached upper
        '{2'd0, 16'h0002, 8'hFF, 8'h00, 4'd11},  // R11 foreign port
        '{2'd2, 16'h9000, 8'h00, 8'hA5, 4'd11},  // R11 lower untouched
        '{2'd2, 16'hE000, 8'h00, 8'hC3, 4'd11},  // R11 upper untouched
        '{2'd0, 16'hFF00, 8'h11, 8'h00, 4'd6},   // R6 aliased port 0
        '{2'd1, 16'hAB00, 8'h00, 8'h11, 4'd6}    // R6 aliased read
    };

    task automatic check(input string req, input string what,
                         input logic [15:0] act, input logic [15:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s %s actual=%h expected=%h", req, what, act, exp);
        end
    endtask

    task automatic bus_idle();
        iorq_n = 1'b1; mreq_n = 1'b1; wr_n = 1'b1; rd_n = 1'b1;
    endtask

    task automatic io_write(input logic [15:0] a, input logic [7:0] d);
        @(negedge clk);
        addr = a; din = d; iorq_n = 1'b0; wr_n = 1'b0;
        @(negedge clk);
        bus_idle();
    endtask

    task automatic io_read(input logic [15:0] a, output logic [8:0] got);
        @(negedge clk);
        addr = a; iorq_n = 1'b0; rd_n = 1'b0;
        #2;
        got = {dout_oe, dout};
        @(negedge clk);
        bus_idle();
    endtask

    task automatic mem_probe(input logic [15:0] a, output logic [7:0] got);
        @(negedge clk);
        addr = a; mreq_n = 1'b0; rd_n = 1'b0;
        #2;
        got = ba;
        @(negedge clk);
        bus_idle();
    endtask

    initial begin
        #(200000 * 10);
        if (!done) begin
            checks++;
            errors++;
            $display("FAIL watchdog expired");
            $display("  CHECKS %0d ERRORS %0d", checks, errors);
            $finish;
        end
    end

    initial begin
        logic [7:0] b;
        logic [8:0] r;
        rst_n = 1'b0;
        addr  = '0;
        din   = '0;
        bus_idle();
        repeat (3) @(posedge clk);
        @(negedge clk);
        rst_n = 1'b1;

        // R9: both windows clear after reset
        mem_probe(16'h8000, b);
        check("R9", "lower after reset", {8'h0, b}, 16'h0000);
        mem_probe(16'hC000, b);
        check("R9", "upper after reset", {8'h0, b}, 16'h0000);
        io_read(16'h0001, r);
        check("R9", "readback after reset", {7'h0, r}, 16'h0100);

        for (int i = 0; i < NV; i++) begin
            string tag;
            tag = $sformatf("R%0d", VECS[i].req);
            case (VECS[i].op)
                2'd0: io_write(VECS[i].a, VECS[i].d);
                2'd1: begin
                    io_read(VECS[i].a, r);
                    check(tag, $sformatf("vec %0d read", i), {7'h0, r},
                          {7'h0, 1'b1, VECS[i].exp});
                end
                default: begin
                    mem_probe(VECS[i].a, b);
                    check(tag, $sformatf("vec %0d ba", i), {8'h0, b},
                          {8'h0, VECS[i].exp});
                end
            endcase
        end
        // State now: lower = 0x11, upper = 0xC3

        // R8: idle bus gives no read-back
        @(negedge clk);
        #2;
        check("R8", "idle oe/dout", {7'h0, dout_oe, dout}, 16'h0000);

        // R5: upper address with mreq_n high gives zero
        @(negedge clk);
        addr = 16'hC000;
        #2;
        check("R5", "mreq high", {8'h0, ba}, 16'h0000);

        // R10: held I/O write with changing data loads only the first byte
        @(negedge clk);
        addr = 16'h0000; din = 8'h22; iorq_n = 1'b0; wr_n = 1'b0;
        @(negedge clk);
        din = 8'h99;
        repeat (2) @(negedge clk);
        bus_idle();
        mem_probe(16'hA000, b);
        check("R10", "single load per cycle", {8'h0, b}, 16'h0022);

        // R11: memory writes to port-like addresses do not load
        @(negedge clk);
        addr = 16'h0000; din = 8'h5A; mreq_n = 1'b0; wr_n = 1'b0;
        @(negedge clk);
        addr = 16'h0001;
        @(negedge clk);
        bus_idle();
        mem_probe(16'h8000, b);
        check("R11", "lower after mem write", {8'h0, b}, 16'h0022);
        mem_probe(16'hFFFF, b);
        check("R11", "upper after mem write", {8'h0, b}, 16'h00C3);

        // R9: reset pulse mid-run clears both
        @(negedge clk);
        rst_n = 1'b0;
        @(negedge clk);
        rst_n = 1'b1;
        mem_probe(16'hBFFF, b);
        check("R9", "lower after mid reset", {8'h0, b}, 16'h0000);
        mem_probe(16'hC000, b);
        check("R9", "upper after mid reset", {8'h0, b}, 16'h0000);

        done = 1;
        $display("  CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

endmodule